// File: doc/BRIEF.md
# GPIO Port Mode and Data Register Bank

This block holds the per-port mode settings of a general-purpose I/O expander and turns them into pin controls. A serial command receiver in front of it hands over write and read strobes, each with an 8-bit address and an 8-bit data byte. Every port has a 2-bit mode field. The mode makes the port a driven output, a plain input, or an input with its pullup switched on. The block drives an output enable, an output level and a pullup enable for every port. It also returns pin levels when the per-port data addresses are read.

Mode fields sit four to a byte. Port numbers start at `FIRST_PORT` (4 by default), so mode register k holds ports FIRST_PORT+4k up to FIRST_PORT+4k+3. Each port has a single data bit, kept at its own address in a separate range. That bit sets the output level when the port drives. On an input port the same address reads the synchronised pin level instead. Pin vectors are indexed from 0, so index i belongs to port FIRST_PORT+i.

Top module: `gpio_cfg_bank`

## Requirements
- R1: While reset is asserted and just after it is released, every mode field holds code 11. As a result pin_oe is all zero, pin_out is all zero, pin_pu is all one, rsvd_mode is 0 and rdata is 0x00.
- R2: A write to mode address CFG_FIRST+k (0x09 to 0x0F by default) stores the byte. Bits [2j+1:2j] set the mode of port index 4k+j, so the highest-numbered port sits in bits 7:6. The pin outputs follow on the clock edge that takes the write.
- R3: Mode code 01 sets pin_oe to 1 and pin_pu to 0. pin_out then equals the port's stored data bit, so the pin drives low for 0 and high for 1. pin_out is 0 in every other mode.
- R4: Mode code 10 sets pin_oe to 0 and pin_pu to 0. A read of the port's data address returns {7'b0, pin level}, where the pin level has passed through SYNC_STAGES (default 2) flip-flop stages.
- R5: Mode code 11 sets pin_oe to 0 and pin_pu to 1. Reads of the data address behave as in R4.
- R6: Reserved code 00 is handled like code 10: no drive and no pullup, with reads returning the pin level. rsvd_mode is 1 exactly while at least one port holds code 00.
- R7: A write to data address DATA_BASE+port (0x24 for port 4 up to 0x3F for port 31) stores wdata bit 0. On an input-mode port this leaves pin_oe and pin_out unchanged. The stored bit is driven once the port is later switched to code 01.
- R8: Read data is registered. rdata is valid in the cycle after rd_en and is 0x00 in cycles that follow no read. A mode address returns its stored byte unchanged. A data address of an output port returns {7'b0, stored bit}.
- R9: Any address that is neither a mode nor a data address reads as 0x00. A write to such an address changes no output. No output changes without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe from the command receiver |
| rd_en | input | 1 | Read strobe from the command receiver |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data |
| pin_in | input | NUM_PORTS | Pin levels as seen at the pads |
| pin_oe | output | NUM_PORTS | Per-port output enable |
| pin_out | output | NUM_PORTS | Per-port output level |
| pin_pu | output | NUM_PORTS | Per-port pullup enable |
| rsvd_mode | output | 1 | At least one port holds reserved code 00 |

## Verification
Directed writes place all four mode codes in a single byte. This shows whether the bit-pair order and the decode of each code are correct, port by port. Data writes to input ports, followed by a switch to output mode, separate a bit that has been stored but is not yet driven from a bit that is driven straight away. Reads at the edges of both address ranges, and just outside them, expose off-by-one errors in the decode. Random mixes of mode bytes, data bits, pin levels and addresses are then compared against a bench model after every operation, with mode bytes sometimes kept free of code 00 so that rsvd_mode is seen both rising and falling.

// File: rtl/gcfg_pkg.sv
package gcfg_pkg;

   typedef enum logic [1:0] {
      PM_RSVD = 2'b00,
      PM_OUT  = 2'b01,
      PM_IN   = 2'b10,
      PM_PULL = 2'b11
   } pmode_t;

   localparam int MODE_BITS     = 2;
   localparam int PORTS_PER_REG = 8 / MODE_BITS;

endpackage

// File: rtl/gcfg_sync.sv
module gcfg_sync #(
   parameter int WIDTH  = 28,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 0) begin : g_bad_stages
      $error("gcfg_sync: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_direct
      assign q = d;
   end else begin : g_chain
      logic [WIDTH-1:0] st [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st[i] <= '0;
         end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
         end
      end
      assign q = st[STAGES-1];
   end

endmodule

// File: rtl/gcfg_port_cell.sv
module gcfg_port_cell
   import gcfg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   data_we,
   input  logic   wbit,
   input  pmode_t mode,
   input  logic   pin_lvl,
   output logic   oe,
   output logic   out,
   output logic   pu,
   output logic   rd_bit,
   output logic   rsvd
);

   logic data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= 1'b0;
      else if (data_we) data_q <= wbit;
   end

   always_comb begin
      oe   = 1'b0;
      pu   = 1'b0;
      rsvd = 1'b0;
      unique case (mode)
         PM_OUT:  oe   = 1'b1;
         PM_PULL: pu   = 1'b1;
         PM_IN:   ;
         PM_RSVD: rsvd = 1'b1;
         default: ;
      endcase
      out    = oe & data_q;
      rd_bit = oe ? data_q : pin_lvl;
   end

   assert_drive_excludes_pull_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(oe && pu));

   assert_level_only_when_driving_R3: assert property (@(posedge clk) disable iff (!rst_n)
      out |-> oe);

   assert_stored_bit_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && mode == PM_OUT) |=> (mode != PM_OUT || out == $past(wbit)));

endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
   import gcfg_pkg::*;
#(
   parameter int NUM_PORTS   = 28,
   parameter int FIRST_PORT  = 4,
   parameter int CFG_FIRST   = 9,
   parameter int DATA_BASE   = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic [7:0]           addr,
   input  logic [7:0]           wdata,
   output logic [7:0]           rdata,
   input  logic [NUM_PORTS-1:0] pin_in,
   output logic [NUM_PORTS-1:0] pin_oe,
   output logic [NUM_PORTS-1:0] pin_out,
   output logic [NUM_PORTS-1:0] pin_pu,
   output logic                 rsvd_mode
);

   localparam int NUM_REGS   = NUM_PORTS / PORTS_PER_REG;
   localparam int CFG_LAST   = CFG_FIRST + NUM_REGS - 1;
   localparam int DATA_FIRST = DATA_BASE + FIRST_PORT;
   localparam int DATA_LAST  = DATA_FIRST + NUM_PORTS - 1;

   if (NUM_PORTS % PORTS_PER_REG != 0 || NUM_PORTS < PORTS_PER_REG) begin : g_bad_ports
      $error("gpio_cfg_bank: NUM_PORTS must be a positive multiple of four");
   end
   if (FIRST_PORT % PORTS_PER_REG != 0) begin : g_bad_first
      $error("gpio_cfg_bank: FIRST_PORT must be a multiple of four");
   end
   if (CFG_FIRST < 1 || CFG_LAST >= DATA_FIRST || DATA_LAST > 255) begin : g_bad_map
      $error("gpio_cfg_bank: address ranges overlap or exceed 8 bits");
   end

   logic [7:0]           cfg_q [NUM_REGS];
   logic [NUM_PORTS-1:0] pin_sync;
   logic [NUM_PORTS-1:0] rd_bit;
   logic [NUM_PORTS-1:0] rsvd;
   logic [7:0]           rd_mux;
   logic [7:0]           rdata_q;

   gcfg_sync #(.WIDTH(NUM_PORTS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (pin_sync)
   );

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_cfg
      localparam logic [7:0] REG_ADDR = 8'(CFG_FIRST + r);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             cfg_q[r] <= 8'hFF;
         else if (wr_en && addr == REG_ADDR)     cfg_q[r] <= wdata;
      end
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      localparam logic [7:0] DAT_ADDR = 8'(DATA_FIRST + p);
      localparam int         REG      = p / PORTS_PER_REG;
      localparam int         LSB      = MODE_BITS * (p % PORTS_PER_REG);
      pmode_t mode;
      assign mode = pmode_t'(cfg_q[REG][LSB +: MODE_BITS]);

      gcfg_port_cell u_cell (
         .clk     (clk),
         .rst_n   (rst_n),
         .data_we (wr_en && addr == DAT_ADDR),
         .wbit    (wdata[0]),
         .mode    (mode),
         .pin_lvl (pin_sync[p]),
         .oe      (pin_oe[p]),
         .out     (pin_out[p]),
         .pu      (pin_pu[p]),
         .rd_bit  (rd_bit[p]),
         .rsvd    (rsvd[p])
      );
   end

   assign rsvd_mode = |rsvd;

   always_comb begin
      rd_mux = 8'h00;
      for (int r = 0; r < NUM_REGS; r++) begin
         if (addr == 8'(CFG_FIRST + r)) rd_mux = cfg_q[r];
      end
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (addr == 8'(DATA_FIRST + p)) rd_mux = {7'b0, rd_bit[p]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_q <= 8'h00;
      else        rdata_q <= rd_en ? rd_mux : 8'h00;
   end

   assign rdata = rdata_q;

   assert_reset_no_drive_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pin_oe == '0 && pin_pu == '1 && !rsvd_mode));

   assert_rsvd_needs_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rsvd_mode) |-> $past(wr_en));

   assert_idle_rdata_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rd_en) |-> rdata == 8'h00);

   assert_quiet_without_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(pin_oe) && $stable(pin_pu) && $stable(pin_out) && $stable(rsvd_mode)));

endmodule

// File: tb/gpio_cfg_bank_tb.sv
module gpio_cfg_bank_tb;

   localparam int NP = 28;
   localparam int NR = NP / 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [7:0]    addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic [NP-1:0] pin_in = '0;
   logic [NP-1:0] pin_oe, pin_out, pin_pu;
   logic          rsvd_mode;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   logic [7:0] m_cfg [NR];
   logic       m_dat [NP];

   always #10 clk = ~clk;

   gpio_cfg_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_oe(pin_oe),
      .pin_out(pin_out), .pin_pu(pin_pu), .rsvd_mode(rsvd_mode)
   );

   function automatic logic [1:0] mode_of(int p);
      return m_cfg[p/4][2*(p%4) +: 2];
   endfunction

   function automatic logic [NP-1:0] exp_oe();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = (mode_of(p) == 2'b01);
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_out();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = (mode_of(p) == 2'b01) && m_dat[p];
      return v;
   endfunction

   function automatic logic [NP-1:0] exp_pu();
      logic [NP-1:0] v;
      for (int p = 0; p < NP; p++) v[p] = (mode_of(p) == 2'b11);
      return v;
   endfunction

   function automatic logic exp_rsvd();
      for (int p = 0; p < NP; p++) if (mode_of(p) == 2'b00) return 1'b1;
      return 1'b0;
   endfunction

   function automatic logic [7:0] exp_read(logic [7:0] a);
      int p;
      if (a >= 8'h09 && a <= 8'h0F) return m_cfg[a - 8'h09];
      if (a >= 8'h24 && a <= 8'h3F) begin
         p = a - 8'h24;
         return {7'b0, (mode_of(p) == 2'b01) ? m_dat[p] : pin_in[p]};
      end
      return 8'h00;
   endfunction

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_pins(string req);
      chk(req, "pin_oe",    64'(pin_oe),    64'(exp_oe()));
      chk(req, "pin_out",   64'(pin_out),   64'(exp_out()));
      chk(req, "pin_pu",    64'(pin_pu),    64'(exp_pu()));
      chk(req, "rsvd_mode", 64'(rsvd_mode), 64'(exp_rsvd()));
   endtask

   task automatic do_write(logic [7:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
      if (a >= 8'h09 && a <= 8'h0F) m_cfg[a - 8'h09] = d;
      if (a >= 8'h24 && a <= 8'h3F) m_dat[a - 8'h24] = d[0];
   endtask

   task automatic do_read(string req, logic [7:0] a);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      chk(req, $sformatf("rdata@%h", a), 64'(rdata), 64'(exp_read(a)));
   endtask

   task automatic set_pins(logic [NP-1:0] v);
      @(negedge clk);
      pin_in = v;
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      int cyc = 0;
      while (!done) begin
         @(posedge clk);
         cyc++;
         if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
         end
      end
   end

   initial begin
      logic [7:0] b;
      logic [7:0] a;
      int op;
      void'($urandom(32'd4711));
      for (int r = 0; r < NR; r++) m_cfg[r] = 8'hFF;
      for (int p = 0; p < NP; p++) m_dat[p] = 1'b0;
      pin_in = NP'($urandom);
      repeat (3) @(negedge clk);
      // R1: outputs during reset
      chk("R1", "rdata in reset", 64'(rdata), 64'h0);
      chk_pins("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk_pins("R1");
      do_read("R1", 8'h09);
      do_read("R1", 8'h0F);

      // R2/R3/R4/R5/R6: all four codes in one byte: P7=01 P6=10 P5=11 P4=00
      do_write(8'h09, 8'b01_10_11_00);
      chk_pins("R2");
      chk("R3", "P7 oe", 64'(pin_oe[3]), 64'h1);
      chk("R4", "P6 pu", 64'(pin_pu[2]), 64'h0);
      chk("R5", "P5 pu", 64'(pin_pu[1]), 64'h1);
      chk("R6", "P4 oe/pu", 64'({pin_oe[0], pin_pu[0]}), 64'h0);
      chk("R6", "rsvd set", 64'(rsvd_mode), 64'h1);
      do_write(8'h27, 8'h01);
      chk("R3", "P7 drives 1", 64'(pin_out[3]), 64'h1);
      do_write(8'h27, 8'hFE);
      chk("R3", "P7 drives 0", 64'(pin_out[3]), 64'h0);
      // R7: data to input port not driven, then driven after mode change
      do_write(8'h26, 8'h01);
      chk("R7", "P6 undriven", 64'({pin_oe[2], pin_out[2]}), 64'h0);
      set_pins('0);
      do_read("R4", 8'h26);
      set_pins('1);
      do_read("R5", 8'h25);
      do_read("R6", 8'h24);
      do_write(8'h09, 8'b01_01_11_11);
      chk("R7", "P6 now drives stored", 64'(pin_out[2]), 64'h1);
      chk("R6", "rsvd cleared", 64'(rsvd_mode), 64'h0);
      do_read("R8", 8'h26);
      do_read("R8", 8'h09);
      // upper boundary: P31 at 0x0F bits 7:6, data 0x3F
      do_write(8'h0F, 8'b01_11_11_11);
      do_write(8'h3F, 8'h01);
      chk("R2", "P31 drives", 64'({pin_oe[27], pin_out[27]}), 64'h3);
      do_read("R8", 8'h3F);
      // R9: unimplemented addresses
      do_write(8'h08, 8'h00);
      do_write(8'h10, 8'h00);
      do_write(8'h23, 8'h01);
      do_write(8'h40, 8'h55);
      chk_pins("R9");
      do_read("R9", 8'h00);
      do_read("R9", 8'h08);
      do_read("R9", 8'h10);
      do_read("R9", 8'h23);
      do_read("R9", 8'h40);
      do_read("R9", 8'hFF);

      // random mix
      for (int i = 0; i < 600; i++) begin
         op = $urandom_range(0, 9);
         if (op < 3) begin
            a = 8'(8'h09 + $urandom_range(0, NR - 1));
            b = 8'($urandom);
            if ($urandom_range(0, 1) == 1)
               for (int j = 0; j < 4; j++) if (b[2*j +: 2] == 2'b00) b[2*j +: 2] = 2'b10;
            do_write(a, b);
            chk_pins("R2");
         end else if (op < 5) begin
            do_write(8'(8'h24 + $urandom_range(0, NP - 1)), 8'($urandom));
            chk_pins("R7");
         end else if (op < 6) begin
            do_write(8'($urandom), 8'($urandom));
            chk_pins("R9");
         end else if (op < 7) begin
            set_pins(NP'($urandom));
            chk_pins("R9");
         end else if (op < 9) begin
            do_read("R8", ($urandom_range(0, 1) == 1) ? 8'(8'h24 + $urandom_range(0, NP - 1))
                                                      : 8'(8'h09 + $urandom_range(0, NR - 1)));
         end else begin
            do_read("R9", 8'($urandom));
         end
      end
      done = 1;
      summary();
   end

endmodule